// File: doc/BRIEF.md
# Bidirectional Saturating Shifter

This block shifts a signed fixed-point word by a signed amount. A non-negative amount shifts left. When the true product does not fit, a left shift clamps to the largest or smallest code of the selected width, chosen by the operand's sign. A negative amount shifts right by its magnitude. Right shifts are arithmetic. An optional rounding mode adds back the last bit shifted out, which rounds to nearest.

The block works on one of two word widths, a narrow one of 16 bits and a full one of 32 bits, chosen per operation by a select input. In narrow mode only the low half of the operand is read, and the result comes back sign-extended to the full port width. The datapath is combinational and is captured by one output register, so a new operation can be issued every clock.

Top module: `bidir_sat_shifter`

## Requirements
- R1: `rst` is synchronous and active high. The cycle after any clock edge with `rst` high, `result` reads 0.
- R2: An amount of 0 returns the operand unchanged. In narrow mode this is the sign extension of `opnd[15:0]`.
- R3: A left shift whose exact value fits in the selected width returns that value, for both operand signs.
- R4: A left shift that does not fit clamps by operand sign. In narrow mode the clamp values are 0x7FFF and 0x8000; in full mode they are 0x7FFFFFFF and 0x80000000. Any nonzero operand shifted left by the width or more clamps.
- R5: A right shift without rounding is arithmetic: the sign is copied in and the result rounds toward minus infinity.
- R6: Without rounding, a right shift of 15 or more (narrow) or 31 or more (full) gives all ones for a negative operand and 0 otherwise.
- R7: With rounding on and a right shift of m in the range 1 to width-1, operand bit m-1 is added to the truncated result.
- R8: With rounding on, a right shift of 16 or more (narrow) or 32 or more (full) gives 0.
- R9: Rounding has no effect on left shifts or on an amount of 0.
- R10: `shamt` is a 7-bit two's complement value, range -64 to +63. Any magnitude of 32 or more acts exactly like 32.
- R11: In narrow mode, `opnd[31:16]` is ignored, and `result[31:16]` repeats bit 15 of the narrow result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd | input | 32 | Operand; only bits 15:0 are used in narrow mode |
| shamt | input | 7 | Signed shift amount, positive = left, negative = right |
| wide | input | 1 | 1 = 32-bit word, 0 = 16-bit word |
| rnd_en | input | 1 | 1 = round-to-nearest on right shifts |
| result | output | 32 | Registered shifted word, sign-extended in narrow mode |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the only storage on the path is the output register. The bench drives the operand, amount and mode bits on a falling edge. It reads `result` on the next falling edge, after exactly one rising edge, and compares it with a reference model written from the requirements. The properties use the same timing: each one relates the inputs at one edge to `result` at the following edge.

// File: rtl/bss_pkg.sv
package bss_pkg;
  // Which computed lane feeds the output register
  typedef enum logic {
    LANE_NARROW = 1'b0,
    LANE_WIDE   = 1'b1
  } lane_t;

  localparam int NUM_LANES = 2;
endpackage

// File: rtl/bss_count_decode.sv
module bss_count_decode #(
  parameter int CNT_W   = 7,
  parameter int MAG_CAP = 32,
  parameter int MAG_W   = 6
) (
  input  logic [CNT_W-1:0] shamt,
  output logic             go_right,
  output logic [MAG_W-1:0] mag
);
  logic [CNT_W-1:0] abs_v;

  always_comb begin
    go_right = shamt[CNT_W-1];
    // unsigned magnitude; the most negative code maps to 2**(CNT_W-1)
    abs_v = go_right ? (~shamt + 1'b1) : shamt;
    if (abs_v > CNT_W'(MAG_CAP))
      mag = MAG_W'(MAG_CAP);
    else
      mag = abs_v[MAG_W-1:0];
  end
endmodule

// File: rtl/bss_left_sat.sv
module bss_left_sat #(
  parameter int W     = 16,
  parameter int MAG_W = 6
) (
  input  logic [W-1:0]     x,
  input  logic [MAG_W-1:0] m,
  output logic [W-1:0]     y
);
  localparam int EXT_W = 2 * W;
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [MAG_W-1:0] m_eff;
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] shifted;
  logic [W:0]       head;
  logic             fits;

  always_comb begin
    m_eff   = (m > MAG_W'(W)) ? MAG_W'(W) : m;
    ext     = {{W{x[W-1]}}, x};
    shifted = ext << m_eff;
    // the value fits when everything from bit W-1 up is a copy of one sign
    head    = shifted[EXT_W-1:W-1];
    fits    = (head == '0) || (head == '1);
    if (fits)
      y = shifted[W-1:0];
    else
      y = x[W-1] ? NEG_LIM : POS_LIM;
  end
endmodule

// File: rtl/bss_right_arith.sv
module bss_right_arith #(
  parameter int W     = 16,
  parameter int MAG_W = 6
) (
  input  logic [W-1:0]     x,
  input  logic [MAG_W-1:0] m,
  input  logic             rnd,
  output logic [W-1:0]     y
);
  localparam int IDX_W = $clog2(W);
  localparam logic [MAG_W-1:0] LAST = MAG_W'(W - 1);

  logic [MAG_W-1:0] m_tr;
  logic [W-1:0]     trunc;
  logic [IDX_W-1:0] gidx;
  logic             guard;

  always_comb begin
    m_tr  = (m > LAST) ? LAST : m;
    trunc = W'($signed(x) >>> m_tr);
    gidx  = IDX_W'(m - 1'b1);
    guard = (m != '0) && (m <= LAST) && x[gidx];
    if (!rnd)
      y = trunc;
    else if (m > LAST)
      y = '0;
    else
      y = trunc + {{(W-1){1'b0}}, guard};
  end
endmodule

// File: rtl/bidir_sat_shifter.sv
module bidir_sat_shifter
  import bss_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int CNT_W    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd,
  input  logic [CNT_W-1:0]  shamt,
  input  logic              wide,
  input  logic              rnd_en,
  output logic [DATA_W-1:0] result
);
  localparam int MAG_CAP = DATA_W;
  localparam int MAG_W   = $clog2(MAG_CAP + 1);

  logic             go_right;
  logic [MAG_W-1:0] mag;
  logic [DATA_W-1:0] lane_out [NUM_LANES];
  logic [DATA_W-1:0] next_res;
  lane_t             lane_sel;

  bss_count_decode #(
    .CNT_W  (CNT_W),
    .MAG_CAP(MAG_CAP),
    .MAG_W  (MAG_W)
  ) u_dec (
    .shamt   (shamt),
    .go_right(go_right),
    .mag     (mag)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == int'(LANE_NARROW)) ? NARROW_W : DATA_W;
    logic [LW-1:0] lx, ly, ry, sel;

    assign lx = opnd[LW-1:0];

    bss_left_sat #(.W(LW), .MAG_W(MAG_W)) u_left (
      .x(lx), .m(mag), .y(ly)
    );

    bss_right_arith #(.W(LW), .MAG_W(MAG_W)) u_right (
      .x(lx), .m(mag), .rnd(rnd_en), .y(ry)
    );

    assign sel         = go_right ? ry : ly;
    assign lane_out[g] = DATA_W'($signed(sel));
  end

  assign lane_sel = lane_t'(wide);
  assign next_res = lane_out[int'(lane_sel)];

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end
endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int CNT_W    = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opnd,
  input logic [CNT_W-1:0]  shamt,
  input logic              wide,
  input logic              rnd_en,
  input logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] FULL_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] FULL_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CNT_W-1:0] neg_mag;
  assign neg_mag = ~shamt + 1'b1;

  p_reset_r1: assert property (@(posedge clk) rst |=> (result == '0));

  p_zero_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    (wide && shamt == '0) |=> (result == $past(opnd)));

  p_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (wide && !shamt[CNT_W-1] && shamt >= CNT_W'(DATA_W) && opnd != '0)
    |=> (result == FULL_POS || result == FULL_NEG));

  p_right_sign_r5: assert property (@(posedge clk) disable iff (rst)
    (wide && !rnd_en && shamt[CNT_W-1] && opnd[DATA_W-1]) |=> result[DATA_W-1]);

  p_round_big_r8: assert property (@(posedge clk) disable iff (rst)
    (wide && rnd_en && shamt[CNT_W-1] && neg_mag >= CNT_W'(DATA_W))
    |=> (result == '0));

  p_narrow_ext_r11: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (result[DATA_W-1:NARROW_W-1] == '0 || result[DATA_W-1:NARROW_W-1] == '1));
endmodule

bind bidir_sat_shifter bss_checker #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .CNT_W   (CNT_W)
) u_bss_chk (
  .clk   (clk),
  .rst   (rst),
  .opnd  (opnd),
  .shamt (shamt),
  .wide  (wide),
  .rnd_en(rnd_en),
  .result(result)
);

// File: tb/bidir_sat_shifter_test.sv
`timescale 1ns/1ps
module bidir_sat_shifter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] opnd;
  logic [6:0]  shamt;
  logic        wide;
  logic        rnd_en;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bidir_sat_shifter uut (
    .clk(clk), .rst(rst), .opnd(opnd), .shamt(shamt),
    .wide(wide), .rnd_en(rnd_en), .result(result)
  );

  // Reference written from the requirements, using 64-bit integer arithmetic
  function automatic logic [31:0] ref_fn(logic [31:0] op, int sh, logic w, logic r);
    int     wd;
    int     m;
    longint x, mx, mn, p;
    wd = w ? 32 : 16;
    x  = w ? longint'($signed(op)) : longint'($signed(op[15:0]));
    mx = (64'sd1 <<< (wd - 1)) - 1;
    mn = -mx - 1;
    if (sh >= 0) begin
      if (x == 0)        p = 0;
      else if (sh >= wd) p = (x > 0) ? mx : mn;
      else begin
        p = x <<< sh;
        if (p > mx)      p = mx;
        else if (p < mn) p = mn;
      end
    end else begin
      m = -sh;
      if (r) begin
        if (m > wd - 1) p = 0;
        else            p = (x >>> m) + ((x >>> (m - 1)) & 64'sd1);
      end else begin
        if (m > wd - 1) m = wd - 1;
        p = x >>> m;
      end
    end
    return p[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, read after exactly one rising edge
  task automatic run(string tag, logic [31:0] op, int sh, logic w, logic r, logic [31:0] exp);
    @(negedge clk);
    opnd = op; shamt = 7'(sh); wide = w; rnd_en = r;
    @(negedge clk);
    chk(tag, result, exp);
    chk({tag, " model"}, result, ref_fn(op, sh, w, r));
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    rst = 1'b1; opnd = 32'h1234_5678; shamt = 7'd3; wide = 1'b1; rnd_en = 1'b0;
    @(negedge clk);
    chk("R1 held in reset", result, 32'h0);
    @(negedge clk);
    chk("R1 still reset", result, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_zero_r2();
    run("R2 full zero", 32'h8765_4321, 0, 1'b1, 1'b0, 32'h8765_4321);
    run("R2 narrow zero", 32'h1234_F00D, 0, 1'b0, 1'b0, 32'hFFFF_F00D);
  endtask

  task automatic t_left_fit_r3();
    run("R3 full", 32'h0000_1234, 4, 1'b1, 1'b0, 32'h0001_2340);
    run("R3 narrow", 32'h0000_0123, 3, 1'b0, 1'b0, 32'h0000_0918);
    run("R3 narrow neg", 32'h0000_FFF0, 4, 1'b0, 1'b0, 32'hFFFF_FF00);
    run("R3 full exact min", 32'hC000_0000, 1, 1'b1, 1'b0, 32'h8000_0000);
  endtask

  task automatic t_left_sat_r4();
    run("R4 full pos", 32'h4000_0000, 1, 1'b1, 1'b0, 32'h7FFF_FFFF);
    run("R4 full neg", 32'hBFFF_FFFF, 1, 1'b1, 1'b0, 32'h8000_0000);
    run("R4 narrow pos", 32'h0000_4000, 1, 1'b0, 1'b0, 32'h0000_7FFF);
    run("R4 narrow big", 32'h0000_0001, 20, 1'b0, 1'b0, 32'h0000_7FFF);
    run("R4 narrow neg", 32'h0000_FFFF, 16, 1'b0, 1'b0, 32'hFFFF_8000);
  endtask

  task automatic t_right_r5();
    run("R5 full neg", 32'h8000_0010, -4, 1'b1, 1'b0, 32'hF800_0001);
    run("R5 narrow neg", 32'h0000_FF80, -3, 1'b0, 1'b0, 32'hFFFF_FFF0);
    run("R5 narrow pos", 32'h0000_7FFF, -1, 1'b0, 1'b0, 32'h0000_3FFF);
  endtask

  task automatic t_right_big_r6();
    run("R6 full neg 31", 32'h8000_0000, -31, 1'b1, 1'b0, 32'hFFFF_FFFF);
    run("R6 full pos 31", 32'h7FFF_FFFF, -31, 1'b1, 1'b0, 32'h0000_0000);
    run("R6 narrow neg 15", 32'h0000_8000, -15, 1'b0, 1'b0, 32'hFFFF_FFFF);
    run("R6 narrow pos 20", 32'h0000_7FFF, -20, 1'b0, 1'b0, 32'h0000_0000);
  endtask

  task automatic t_round_r7();
    run("R7 narrow pos", 32'h0000_0003, -1, 1'b0, 1'b1, 32'h0000_0002);
    run("R7 narrow neg", 32'h0000_FFFD, -1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    run("R7 full", 32'h0000_0180, -8, 1'b1, 1'b1, 32'h0000_0002);
    run("R7 full 31", 32'h7FFF_FFFF, -31, 1'b1, 1'b1, 32'h0000_0001);
  endtask

  task automatic t_round_big_r8();
    run("R8 narrow pos", 32'h0000_7FFF, -16, 1'b0, 1'b1, 32'h0000_0000);
    run("R8 narrow neg", 32'h0000_8000, -16, 1'b0, 1'b1, 32'h0000_0000);
    run("R8 full 32", 32'h8000_0000, -32, 1'b1, 1'b1, 32'h0000_0000);
    run("R8 full 64", 32'h8000_0000, -64, 1'b1, 1'b1, 32'h0000_0000);
  endtask

  task automatic t_round_left_r9();
    run("R9 full left", 32'h0000_0003, 2, 1'b1, 1'b1, 32'h0000_000C);
    run("R9 narrow sat", 32'h0000_4000, 1, 1'b0, 1'b1, 32'h0000_7FFF);
    run("R9 zero amount", 32'h0000_0005, 0, 1'b1, 1'b1, 32'h0000_0005);
  endtask

  task automatic t_clamp_r10();
    run("R10 left 63", 32'h1234_5678, 63, 1'b1, 1'b0, 32'h7FFF_FFFF);
    run("R10 right 64 pos", 32'h1234_5678, -64, 1'b1, 1'b0, 32'h0000_0000);
    run("R10 right 64 neg", 32'h8765_4321, -64, 1'b1, 1'b0, 32'hFFFF_FFFF);
    run("R10 right 33 neg", 32'h8765_4321, -33, 1'b1, 1'b0, 32'hFFFF_FFFF);
    run("R10 left 40 neg", 32'hFFFF_FFFF, 40, 1'b1, 1'b0, 32'h8000_0000);
  endtask

  task automatic t_narrow_r11();
    run("R11 upper ignored", 32'hABCD_0123, 3, 1'b0, 1'b0, 32'h0000_0918);
    run("R11 sign extend", 32'h5555_8001, -1, 1'b0, 1'b0, 32'hFFFF_C000);
    run("R11 round upper", 32'hFFFF_0003, -1, 1'b0, 1'b1, 32'h0000_0002);
  endtask

  task automatic t_sweep();
    logic [31:0] st = 32'hACE1_2468;
    logic [31:0] op;
    for (int i = 0; i < 3000; i++) begin
      st = {st[30:0], st[31] ^ st[21] ^ st[1] ^ st[0]};
      op = st[12] ? 32'($signed(st) >>> st[28:24]) : st;
      @(negedge clk);
      opnd = op; shamt = st[22:16]; wide = st[5]; rnd_en = st[9];
      @(negedge clk);
      chk("SWEEP R3 R4 R5 R6 R7 R8", result,
          ref_fn(op, int'($signed(st[22:16])), st[5], st[9]));
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; opnd = '0; shamt = '0; wide = 1'b0; rnd_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_zero_r2();
    t_left_fit_r3();
    t_left_sat_r4();
    t_right_r5();
    t_right_big_r6();
    t_round_r7();
    t_round_big_r8();
    t_round_left_r9();
    t_clamp_r10();
    t_narrow_r11();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule